// File: doc/BRIEF.md
# Conditional Execution and Flag Unit

This block sits beside the execute stage of a processor. Every instruction issued to it can run under a 4-bit condition code. The block checks that code against four stored status flags: negative (N), zero (Z), carry (C) and overflow (V). Once per issue it decides whether the instruction executes. This applies to every instruction, not only to branches. An instruction that fails its condition still takes its issue cycle, but its result and any flag update are dropped. The reserved code 1111 never executes, and the block reports it on a separate indicator.

The flags change only in two cases: an executed instruction has its set-flags bit high, or an executed instruction belongs to the compare class. Any other instruction leaves the flags as they are. The new values come from the ALU result and from the ALU's carry and overflow outputs. They are registered at the clock edge, so the instruction issued in the next cycle already evaluates its condition against them.

Top module: `cexec_unit`

## Requirements
- R1: After reset `flags_q` is 0000 and `exec_en` is 0 while `issue_vld` is low. `flags_q` bit order is N=bit 3, Z=bit 2, C=bit 1, V=bit 0.
- R2: The single-flag codes work as follows. 0000 passes when Z=1 and 0001 when Z=0. 0010 passes when C=1 and 0011 when C=0. 0100 passes when N=1 and 0101 when N=0. 0110 passes when V=1 and 0111 when V=0.
- R3: Code 1000 passes when C=1 and Z=0. Code 1001 passes when C=0 or Z=1.
- R4: Code 1010 passes when N equals V, and 1011 when N differs from V. Code 1100 passes when Z=0 and N equals V. Code 1101 passes when Z=1 or N differs from V.
- R5: Code 1110 passes for every flag value.
- R6: Code 1111 never sets `exec_en`. `cond_rsvd` is high exactly when `issue_vld` is high with code 1111.
- R7: While `issue_vld` is low, `exec_en` is 0 and the flags do not change, whatever the other inputs are.
- R8: An executed instruction with `set_flags` or `is_compare` high loads the flags at the next clock edge. N takes the result MSB, Z is 1 when the result is all zero, C takes `alu_carry` and V takes `alu_ovf`.
- R9: An executed instruction with both `set_flags` and `is_compare` low leaves the flags unchanged.
- R10: An instruction whose condition fails leaves the flags unchanged, even when `set_flags` or `is_compare` is high.
- R11: An instruction issued in the cycle right after a flag update evaluates its condition against the updated flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_vld | input | 1 | An instruction is issued this cycle |
| cond | input | 4 | Condition code of the issued instruction |
| set_flags | input | 1 | Instruction requests a flag update |
| is_compare | input | 1 | Instruction is compare class (always updates flags) |
| alu_res | input | DATA_W | ALU result |
| alu_carry | input | 1 | ALU carry out |
| alu_ovf | input | 1 | ALU signed overflow |
| exec_en | output | 1 | Instruction executes this cycle |
| cond_rsvd | output | 1 | Issued instruction carries the reserved code |
| flags_q | output | 4 | Registered N, Z, C, V |

## Verification
The assertions assume that the ALU inputs and `cond` are steady from just after one rising edge to the next. `exec_en` is combinational and is only meaningful between edges. They also assume that reset is held for at least one edge before any issue. The bench changes every input on the falling edge and reads `exec_en` a few nanoseconds later. It only loads flag values through compare-class issues with chosen results. The stimulus therefore never asks for N and Z to be set together, a pair that no ALU result can produce.

// File: rtl/cx_pkg.sv
package cx_pkg;

   typedef enum logic [3:0] {
      CC_ZS  = 4'h0,
      CC_ZC  = 4'h1,
      CC_CS  = 4'h2,
      CC_CC  = 4'h3,
      CC_NS  = 4'h4,
      CC_NC  = 4'h5,
      CC_VS  = 4'h6,
      CC_VC  = 4'h7,
      CC_UGT = 4'h8,
      CC_ULE = 4'h9,
      CC_SGE = 4'hA,
      CC_SLT = 4'hB,
      CC_SGT = 4'hC,
      CC_SLE = 4'hD,
      CC_ANY = 4'hE,
      CC_RSV = 4'hF
   } cc_code_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

endpackage

// File: rtl/cx_cond_eval.sv
module cx_cond_eval
   import cx_pkg::*;
(
   input  logic [3:0] code,
   input  nzcv_t      fl,
   output logic       pass,
   output logic       rsvd
);
   cc_code_e cc;
   logic     sgn_eq;

   always_comb begin
      cc     = cc_code_e'(code);
      sgn_eq = (fl.n == fl.v);
      rsvd   = 1'b0;
      unique case (cc)
         CC_ZS:   pass = fl.z;
         CC_ZC:   pass = !fl.z;
         CC_CS:   pass = fl.c;
         CC_CC:   pass = !fl.c;
         CC_NS:   pass = fl.n;
         CC_NC:   pass = !fl.n;
         CC_VS:   pass = fl.v;
         CC_VC:   pass = !fl.v;
         CC_UGT:  pass = fl.c && !fl.z;
         CC_ULE:  pass = !fl.c || fl.z;
         CC_SGE:  pass = sgn_eq;
         CC_SLT:  pass = !sgn_eq;
         CC_SGT:  pass = !fl.z && sgn_eq;
         CC_SLE:  pass = fl.z || !sgn_eq;
         CC_ANY:  pass = 1'b1;
         default: begin
            pass = 1'b0;
            rsvd = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/cx_flag_reg.sv
module cx_flag_reg
   import cx_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          ZCHUNK   = 8,
   parameter logic [3:0]  FLAG_RST = 4'b0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] res,
   input  logic              carry,
   input  logic              ovf,
   output nzcv_t             fl_q
);
   localparam int NCHUNK = (DATA_W + ZCHUNK - 1) / ZCHUNK;
   localparam int PADW   = NCHUNK * ZCHUNK;

   if (DATA_W < 2) begin : g_bad_w
      $error("cx_flag_reg: DATA_W must be at least 2");
   end
   if (ZCHUNK < 1) begin : g_bad_c
      $error("cx_flag_reg: ZCHUNK must be at least 1");
   end

   logic              is_zero;
   logic [NCHUNK-1:0] chunk_nz;
   logic [PADW-1:0]   res_pad;

   assign res_pad = PADW'(res);

   if (NCHUNK == 1) begin : g_flat
      assign chunk_nz = |res;
   end else begin : g_split
      for (genvar k = 0; k < NCHUNK; k++) begin : g_ch
         assign chunk_nz[k] = |res_pad[k*ZCHUNK +: ZCHUNK];
      end
   end

   assign is_zero = ~|chunk_nz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_q <= nzcv_t'(FLAG_RST);
      end else if (load) begin
         fl_q.n <= res[DATA_W-1];
         fl_q.z <= is_zero;
         fl_q.c <= carry;
         fl_q.v <= ovf;
      end
   end
endmodule

// File: rtl/cexec_unit.sv
module cexec_unit
   import cx_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          ZCHUNK   = 8,
   parameter logic [3:0]  FLAG_RST = 4'b0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_vld,
   input  logic [3:0]        cond,
   input  logic              set_flags,
   input  logic              is_compare,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              alu_carry,
   input  logic              alu_ovf,
   output logic              exec_en,
   output logic              cond_rsvd,
   output logic [3:0]        flags_q
);
   nzcv_t fl;
   logic  pass;
   logic  rsvd;
   logic  upd;

   cx_cond_eval u_eval (
      .code (cond),
      .fl   (fl),
      .pass (pass),
      .rsvd (rsvd)
   );

   assign exec_en   = issue_vld && pass;
   assign cond_rsvd = issue_vld && rsvd;
   assign upd       = exec_en && (set_flags || is_compare);

   cx_flag_reg #(
      .DATA_W   (DATA_W),
      .ZCHUNK   (ZCHUNK),
      .FLAG_RST (FLAG_RST)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (upd),
      .res   (alu_res),
      .carry (alu_carry),
      .ovf   (alu_ovf),
      .fl_q  (fl)
   );

   assign flags_q = fl;
endmodule

// File: rtl/cexec_unit_chk.sv
module cexec_unit_chk #(
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              issue_vld,
   input logic [3:0]        cond,
   input logic              set_flags,
   input logic              is_compare,
   input logic [DATA_W-1:0] alu_res,
   input logic              alu_carry,
   input logic              alu_ovf,
   input logic              exec_en,
   input logic              cond_rsvd,
   input logic [3:0]        flags_q
);
   // R6: reserved code never executes
   a_r6_rsvd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (cond == 4'hF) |-> !exec_en);

   // R6: indicator follows issue of the reserved code
   a_r6_rsvd_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cond_rsvd == (issue_vld && cond == 4'hF));

   // R5: always code executes when issued
   a_r5_always: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && cond == 4'hE) |-> exec_en);

   // R7: nothing executes or changes without an issue
   a_r7_idle_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_vld |-> !exec_en);

   a_r7_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_vld |=> $stable(flags_q));

   // R9: executed without update request keeps flags
   a_r9_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && !set_flags && !is_compare) |=> $stable(flags_q));

   // R10: failed condition keeps flags
   a_r10_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && !exec_en) |=> $stable(flags_q));

   // R8: requested update loads flags from the ALU outputs
   a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && (set_flags || is_compare)) |=>
         flags_q == {$past(alu_res[DATA_W-1]), $past(alu_res == '0),
                     $past(alu_carry), $past(alu_ovf)});
endmodule

bind cexec_unit cexec_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .issue_vld  (issue_vld),
   .cond       (cond),
   .set_flags  (set_flags),
   .is_compare (is_compare),
   .alu_res    (alu_res),
   .alu_carry  (alu_carry),
   .alu_ovf    (alu_ovf),
   .exec_en    (exec_en),
   .cond_rsvd  (cond_rsvd),
   .flags_q    (flags_q)
);

// File: tb/sim_cexec_unit.sv
`timescale 1ns/1ps
module sim_cexec_unit;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         issue_vld = 1'b0;
   logic [3:0]   cond = 4'h0;
   logic         set_flags = 1'b0;
   logic         is_compare = 1'b0;
   logic [W-1:0] alu_res = '0;
   logic         alu_carry = 1'b0;
   logic         alu_ovf = 1'b0;
   logic         exec_en;
   logic         cond_rsvd;
   logic [3:0]   flags_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cexec_unit #(.DATA_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .cond(cond),
      .set_flags(set_flags), .is_compare(is_compare), .alu_res(alu_res),
      .alu_carry(alu_carry), .alu_ovf(alu_ovf), .exec_en(exec_en),
      .cond_rsvd(cond_rsvd), .flags_q(flags_q)
   );

   // {cond, nzcv, expected execute}
   localparam int NV = 34;
   localparam logic [8:0] VEC [NV] = '{
      {4'h0, 4'b0100, 1'b1}, {4'h0, 4'b0000, 1'b0},
      {4'h1, 4'b0100, 1'b0}, {4'h1, 4'b0000, 1'b1},
      {4'h2, 4'b0010, 1'b1}, {4'h2, 4'b0000, 1'b0},
      {4'h3, 4'b0010, 1'b0}, {4'h3, 4'b0000, 1'b1},
      {4'h4, 4'b1000, 1'b1}, {4'h4, 4'b0000, 1'b0},
      {4'h5, 4'b1000, 1'b0}, {4'h5, 4'b0000, 1'b1},
      {4'h6, 4'b0001, 1'b1}, {4'h6, 4'b0000, 1'b0},
      {4'h7, 4'b0001, 1'b0}, {4'h7, 4'b0000, 1'b1},
      {4'h8, 4'b0010, 1'b1}, {4'h8, 4'b0110, 1'b0},
      {4'h9, 4'b0010, 1'b0}, {4'h9, 4'b0110, 1'b1}, {4'h9, 4'b0000, 1'b1},
      {4'hA, 4'b1001, 1'b1}, {4'hA, 4'b1000, 1'b0}, {4'hA, 4'b0000, 1'b1},
      {4'hB, 4'b1000, 1'b1}, {4'hB, 4'b0001, 1'b1}, {4'hB, 4'b1001, 1'b0},
      {4'hC, 4'b0000, 1'b1}, {4'hC, 4'b0100, 1'b0}, {4'hC, 4'b1001, 1'b1},
      {4'hC, 4'b0001, 1'b0},
      {4'hD, 4'b0100, 1'b1}, {4'hD, 4'b0000, 1'b0},
      {4'hE, 4'b1011, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [3:0] c, input logic s, input logic cmp,
                        input logic [W-1:0] r, input logic cy, input logic ov);
      @(negedge clk);
      issue_vld = v; cond = c; set_flags = s; is_compare = cmp;
      alu_res = r; alu_carry = cy; alu_ovf = ov;
      #2;
   endtask

   task automatic idle();
      drive(1'b0, 4'h0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
   endtask

   // load flags through an always-code compare (N and Z never both 1)
   task automatic load_flags(input logic [3:0] f);
      logic [W-1:0] r;
      r = f[2] ? '0 : (f[3] ? {1'b1, {(W-1){1'b0}}} : W'(1));
      drive(1'b1, 4'hE, 1'b0, 1'b1, r, f[1], f[0]);
      idle();
   endtask

   function automatic string tag_of(input logic [3:0] c);
      if (c < 4'h8) return "R2";
      if (c < 4'hA) return "R3";
      if (c < 4'hE) return "R4";
      if (c == 4'hE) return "R5";
      return "R6";
   endfunction

   initial begin
      #200_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      chk("R1 flags", 32'(flags_q), 32'h0);
      chk("R1 exec", 32'(exec_en), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [3:0] c, f;
         logic       e;
         {c, f, e} = VEC[i];
         load_flags(f);
         chk("R8 loaded flags", 32'(flags_q), 32'(f));
         drive(1'b1, c, 1'b0, 1'b0, 32'h5, 1'b1, 1'b1);
         chk(tag_of(c), 32'(exec_en), 32'(e));
         idle();
         chk("R9 flags kept", 32'(flags_q), 32'(f));
      end

      // R6 reserved code under several flag states
      for (int k = 0; k < 4; k++) begin
         logic [3:0] f;
         f = (k == 0) ? 4'b0000 : (k == 1) ? 4'b0100 : (k == 2) ? 4'b1011 : 4'b0111;
         load_flags(f);
         drive(1'b1, 4'hF, 1'b1, 1'b1, '0, 1'b1, 1'b1);
         chk("R6 exec", 32'(exec_en), 32'h0);
         chk("R6 rsvd", 32'(cond_rsvd), 32'h1);
         idle();
         chk("R6 rsvd idle", 32'(cond_rsvd), 32'h0);
         chk("R10 rsvd flags", 32'(flags_q), 32'(f));
      end

      // R7 no issue: nothing happens even with update requests
      load_flags(4'b0010);
      drive(1'b0, 4'hE, 1'b1, 1'b1, 32'h8000_0000, 1'b0, 1'b1);
      chk("R7 exec", 32'(exec_en), 32'h0);
      idle();
      chk("R7 flags", 32'(flags_q), 32'h2);

      // R10 failed condition with S and compare
      drive(1'b1, 4'h0, 1'b1, 1'b1, 32'h0, 1'b0, 1'b1);
      chk("R10 exec", 32'(exec_en), 32'h0);
      idle();
      chk("R10 flags", 32'(flags_q), 32'h2);

      // R8 set-flags path with a non-trivial result
      drive(1'b1, 4'h2, 1'b1, 1'b0, 32'hF000_0001, 1'b0, 1'b1);
      chk("R8 exec", 32'(exec_en), 32'h1);
      idle();
      chk("R8 s-bit flags", 32'(flags_q), 32'b1001);

      // R11 back-to-back: compare sets Z, next issue sees it
      drive(1'b1, 4'hE, 1'b0, 1'b1, 32'h0, 1'b1, 1'b0);
      drive(1'b1, 4'h0, 1'b1, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b0);
      chk("R11 sees new Z", 32'(exec_en), 32'h1);
      drive(1'b1, 4'h1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
      chk("R11 second update", 32'(exec_en), 32'h1);
      chk("R11 flags", 32'(flags_q), 32'b0000);
      idle();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule